// File: doc/BRIEF.md
# XOR-Transformed Two-Level Parallel Adder

This block adds two unsigned words of a configurable width and returns their full sum, one bit wider than the operands. It has no clock and no state. The logic is split into two stages. The first stage replaces each bit of operand A with the XOR of that bit and the matching bit of operand B. Operand B passes through this stage unchanged. The second stage is a single flat AND-OR plane that reads only the transformed bits, the B bits and their complements. It produces every sum bit and the carry-out directly.

The plane has no generate gates of the form a AND b, no rippling carry chain and no XOR at the output. A carry into a position is written as a set of product terms, one for each lower position that can start a carry. Each term is that position's "B set, transformed bit clear" literal pair followed by the run of set transformed bits above it. Each sum bit combines the carry-start terms, the carry-stop terms and the all-propagate term, each gated by its own transformed bit. The number of product terms therefore grows with the square of the width. The block is meant to sit where a shallow, regular adder with a predictable two-gate-level plane is preferred over a chained carry path.

Top module: `xor_sop_adder`

## Requirements
- R1: For every pair of operands, `sum_out` equals `opa + opb` computed as an unsigned value WIDTH+1 bits wide.
- R2: Bit WIDTH of `sum_out` is the carry-out. It is 1 exactly when `opa + opb` is 2**WIDTH or more.
- R3: Bit 0 of `sum_out` equals `opa[0] XOR opb[0]`, because there is no carry-in.
- R4: When `opa` is the bitwise complement of `opb`, every position propagates and none generates. The low WIDTH bits of `sum_out` are then all ones and bit WIDTH is 0.
- R5: A carry started at bit 0 crosses the whole word. With `opa` = 1 and `opb` = 2**WIDTH-1, `sum_out` equals 2**WIDTH: only bit WIDTH is set.
- R6: When either operand is zero, `sum_out` equals the other operand with bit WIDTH clear.
- R7: The block is purely combinational. A new pair of operands shows up in `sum_out` within the same cycle, with no register in the path.
- R8: The result is correct at every width the parameter allows. With WIDTH = 4, all 256 operand pairs produce the exact sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| sum_out | output | WIDTH+1 | Unsigned sum; bit WIDTH is the carry-out |

## Verification
Whenever the operands change, the bound checker compares the result against an arithmetic reference. On the same event it also tests the carry-out rule, the carry-free least significant bit, the all-propagate pattern and the zero-operand identity. The bench scenarios cover what a single evaluation cannot show. These are the full-length carry run from bit 0 to the carry-out, the same-cycle response to back-to-back operand changes, and an exhaustive sweep of a narrow instance that proves the generated plane is right at another width.

// File: rtl/xsop_pkg.sv
// Package: shared constants and helpers for the XOR-transformed adder.
// Assumes operand widths stay at or below XSOP_MAX_W so masks fit 64 bits.
package xsop_pkg;

    localparam int XSOP_MAX_W = 63;

    // Returns a mask with bits lo..hi set (inclusive); empty when lo > hi.
    function automatic logic [63:0] span_mask(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < 64; k++) begin
            if (k >= lo && k <= hi) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/xsop_transform.sv
// Module: input transform stage. Each A bit becomes A XOR B; B is
// forwarded unchanged. Uses exactly WIDTH two-input XOR gates.
module xsop_transform #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_bits,
    input  logic [WIDTH-1:0] b_bits,
    output logic [WIDTH-1:0] xt_bits,
    output logic [WIDTH-1:0] yt_bits
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_xor
            // One XOR per bit position.
            assign xt_bits[g] = a_bits[g] ^ b_bits[g];
        end
    endgenerate

    // Pass-through of the untransformed operand.
    assign yt_bits = b_bits;

endmodule

// File: rtl/xsop_term_plane.sv
// Module: AND plane of the two-level array. For every target position i
// (0..WIDTH) and every lower source j < i it forms:
//   start[i][j] = ~X[j] &  y[j] & X[j+1..i-1]   (carry begins at j, survives)
//   stop [i][j] = ~X[j] & ~y[j] & X[j+1..i-1]   (carry killed at j, none above)
// plus allp[i] = X[0..i-1] (no position below i can start or kill a carry).
// Literals are only X, y and their complements. Entries with j >= i are 0.
module xsop_term_plane
    import xsop_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]             xt,
    input  logic [WIDTH-1:0]             yt,
    output logic [WIDTH:0][WIDTH-1:0]    start_t,
    output logic [WIDTH-1:0][WIDTH-1:0]  stop_t,
    output logic [WIDTH-1:0]             allp_t
);

    genvar i, j;
    generate
        for (i = 0; i <= WIDTH; i++) begin : g_row
            for (j = 0; j < WIDTH; j++) begin : g_col
                if (j < i) begin : g_live
                    localparam logic [63:0] RUN = span_mask(j + 1, i - 1);
                    localparam logic [WIDTH-1:0] RUN_N = RUN[WIDTH-1:0];
                    logic run_ok;
                    // AND of the transformed bits strictly between j and i.
                    assign run_ok = &(xt | ~RUN_N);
                    // Carry-start product term.
                    assign start_t[i][j] = ~xt[j] & yt[j] & run_ok;
                    if (i < WIDTH) begin : g_stop
                        // Carry-stop product term.
                        assign stop_t[i][j] = ~xt[j] & ~yt[j] & run_ok;
                    end
                end else begin : g_dead
                    assign start_t[i][j] = 1'b0;
                    if (i < WIDTH) begin : g_stop0
                        assign stop_t[i][j] = 1'b0;
                    end
                end
            end
            if (i < WIDTH) begin : g_allp
                localparam logic [63:0] LOW = span_mask(0, i - 1);
                localparam logic [WIDTH-1:0] LOW_N = LOW[WIDTH-1:0];
                // All-propagate term below position i (1 for i = 0).
                assign allp_t[i] = &(xt | ~LOW_N);
            end
        end
    endgenerate

endmodule

// File: rtl/xsop_or_plane.sv
// Module: OR plane of the two-level array. Sum bit i is 1 when
//   X[i] = 0 and a carry arrives    (any start term of row i), or
//   X[i] = 1 and no carry arrives   (any stop term of row i, or allp[i]).
// X[i] / ~X[i] are folded into each product, so no output XOR exists.
// The carry-out is the OR of the start terms of row WIDTH.
module xsop_or_plane #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]             xt,
    input  logic [WIDTH:0][WIDTH-1:0]    start_t,
    input  logic [WIDTH-1:0][WIDTH-1:0]  stop_t,
    input  logic [WIDTH-1:0]             allp_t,
    output logic [WIDTH:0]               result
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_sum
            logic [WIDTH-1:0] hit_c;
            logic [WIDTH-1:0] hit_n;
            // Widen each product term with its own-position literal.
            assign hit_c = {WIDTH{~xt[i]}} & start_t[i];
            assign hit_n = {WIDTH{xt[i]}}  & stop_t[i];
            // Single OR over all products of this sum bit.
            assign result[i] = (|hit_c) | (|hit_n) | (xt[i] & allp_t[i]);
        end
    endgenerate

    // Carry-out: OR of every carry-start product reaching past the top bit.
    assign result[WIDTH] = |start_t[WIDTH];

endmodule

// File: rtl/xor_sop_adder.sv
// Module: top of the XOR-transformed two-level adder. Combinational only;
// no clock or reset. Bit 0 is the least significant. Assumes
// 1 <= WIDTH <= XSOP_MAX_W. Delay: one XOR level plus one AND-OR plane.
module xor_sop_adder
    import xsop_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH:0]   sum_out
);

    localparam int ROWS = WIDTH + 1;

    logic [WIDTH-1:0]            xt;
    logic [WIDTH-1:0]            yt;
    logic [ROWS-1:0][WIDTH-1:0]  start_t;
    logic [WIDTH-1:0][WIDTH-1:0] stop_t;
    logic [WIDTH-1:0]            allp_t;

    generate
        if (WIDTH < 1 || WIDTH > XSOP_MAX_W) begin : g_bad_width
            $error("xor_sop_adder: WIDTH out of supported range");
        end
    endgenerate

    // Stage 1: XOR transform of operand A against operand B.
    xsop_transform #(.WIDTH(WIDTH)) u_xform (
        .a_bits (opa),
        .b_bits (opb),
        .xt_bits(xt),
        .yt_bits(yt)
    );

    // Stage 2a: product terms.
    xsop_term_plane #(.WIDTH(WIDTH)) u_and (
        .xt     (xt),
        .yt     (yt),
        .start_t(start_t),
        .stop_t (stop_t),
        .allp_t (allp_t)
    );

    // Stage 2b: OR plane producing sum and carry-out.
    xsop_or_plane #(.WIDTH(WIDTH)) u_or (
        .xt     (xt),
        .start_t(start_t),
        .stop_t (stop_t),
        .allp_t (allp_t),
        .result (sum_out)
    );

endmodule

// File: rtl/xor_sop_adder_chk.sv
// Module: property checker for xor_sop_adder, attached by bind.
// Evaluates on every settled change of the operands or the result.
module xor_sop_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH:0]   sum_out
);

    logic [WIDTH:0] ref_sum;
    logic           ref_cout;

    // Arithmetic reference for comparison.
    always_comb begin
        ref_sum  = {1'b0, opa} + {1'b0, opb};
        ref_cout = ({1'b0, opa} + {1'b0, opb}) >= (WIDTH+1)'(1) << WIDTH;
    end

    // Immediate checks of the result against the reference rules.
    always_comb begin
        assert_sum_exact_R1: assert (sum_out == ref_sum)
            else $error("R1 sum mismatch");
        assert_carry_out_R2: assert (sum_out[WIDTH] == ref_cout)
            else $error("R2 carry-out mismatch");
        assert_lsb_no_cin_R3: assert (sum_out[0] == (opa[0] ^ opb[0]))
            else $error("R3 lsb mismatch");
        if (opa == ~opb) begin
            assert_all_prop_R4: assert (sum_out == {1'b0, {WIDTH{1'b1}}})
                else $error("R4 all-propagate mismatch");
        end
        if (opa == '0) begin
            assert_zero_ident_R6: assert (sum_out == {1'b0, opb})
                else $error("R6 zero identity mismatch");
        end
    end

endmodule

bind xor_sop_adder xor_sop_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .opa    (opa),
    .opb    (opb),
    .sum_out(sum_out)
);

// File: tb/xor_sop_adder_test.sv
module xor_sop_adder_test;

    localparam int W  = 16;
    localparam int WS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [W:0]    sum_out;
    logic [WS-1:0] sa = '0;
    logic [WS-1:0] sb = '0;
    logic [WS:0]   ssum;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    xor_sop_adder #(.WIDTH(W))  uut       (.opa(opa), .opb(opb), .sum_out(sum_out));
    xor_sop_adder #(.WIDTH(WS)) uut_small (.opa(sa),  .opb(sb),  .sum_out(ssum));

    // Compare one wide result against its expected value.
    task automatic check_w(input string req, input logic [W:0] exp);
        n_cmp++;
        if (sum_out !== exp) begin
            n_bad++;
            $display("FAIL %s: opa=%h opb=%h got %h expected %h", req, opa, opb, sum_out, exp);
        end
    endtask

    // Apply operands between edges, then sample after settling.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        opa = a;
        opb = b;
        #1;
    endtask

    // Zero inputs after reset release: result zero (R6).
    task automatic t_zero();
        apply('0, '0);
        check_w("R6", '0);
        apply('0, 16'hBEEF);
        check_w("R6", {1'b0, 16'hBEEF});
        apply(16'h1234, '0);
        check_w("R6", {1'b0, 16'h1234});
    endtask

    // Complementary operands: all ones, no carry (R4).
    task automatic t_all_prop();
        apply(16'hA5A5, 16'h5A5A);
        check_w("R4", {1'b0, 16'hFFFF});
        apply(16'h0000, 16'hFFFF);
        check_w("R4", {1'b0, 16'hFFFF});
    endtask

    // Carry from bit 0 through the full width (R5).
    task automatic t_long_carry();
        apply(16'h0001, 16'hFFFF);
        check_w("R5", 17'h10000);
        apply(16'hFFFF, 16'h0001);
        check_w("R5", 17'h10000);
    endtask

    // Carry-out boundary (R2) and largest sum.
    task automatic t_carry_out();
        apply(16'h8000, 16'h7FFF);
        check_w("R2", 17'h0FFFF);
        apply(16'h8000, 16'h8000);
        check_w("R2", 17'h10000);
        apply(16'hFFFF, 16'hFFFF);
        check_w("R2", 17'h1FFFE);
    endtask

    // Bit 0 has no carry-in (R3).
    task automatic t_lsb();
        apply(16'h0001, 16'h0001);
        check_w("R3", 17'h00002);
        apply(16'h0003, 16'h0000);
        check_w("R3", 17'h00003);
    endtask

    // Back-to-back operand changes within one cycle each (R7).
    task automatic t_comb();
        apply(16'h00FF, 16'h0001);
        check_w("R7", 17'h00100);
        opa = 16'h0F0F;
        opb = 16'h0101;
        #1;
        check_w("R7", 17'h01010);
    endtask

    // Random vectors against the arithmetic sum (R1).
    task automatic t_random();
        for (int k = 0; k < 2000; k++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = W'($urandom);
            apply(a, b);
            check_w("R1", {1'b0, a} + {1'b0, b});
        end
    endtask

    // Exhaustive sweep of the narrow instance (R8).
    task automatic t_small_exhaustive();
        for (int a = 0; a < (1 << WS); a++) begin
            for (int b = 0; b < (1 << WS); b++) begin
                logic [WS:0] exp;
                @(negedge clk);
                sa = WS'(a);
                sb = WS'(b);
                #1;
                exp = (WS+1)'(a + b);
                n_cmp++;
                if (ssum !== exp) begin
                    n_bad++;
                    $display("FAIL R8: a=%0d b=%0d got %0d expected %0d", a, b, ssum, exp);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_all_prop();
        t_long_carry();
        t_carry_out();
        t_lsb();
        t_comb();
        t_random();
        t_small_exhaustive();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule